// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Return-Stack Guard

This controller sits beside a small processor core and decides when the core should leave its instruction stream to service an event. Four direct sources (external pin, timer 0, timer 1, serial bus) each latch a request flag on a one-cycle event pulse. A fifth, grouped source collects three more events (timer 2, real-time clock, time base) behind a second level of enables and flags. A global master enable gates acceptance of all five.

When the master enable is set, an enabled request is pending and the return stack has room, the controller accepts the highest-priority request. On the following cycle it raises a one-cycle acknowledge together with a push request for the program counter and a fixed vector address. Acceptance clears the master enable, so a second interrupt is taken only after software sets it again, which is how nesting is allowed. A wake-up output tells the core to leave halt whenever any enabled request is pending, whatever the master enable says.

Software reaches the enables and flags through a small write port and a combinational read port. Registers: address 0 holds the master enable in bit 0 and the enables for external, timer 0, timer 1, serial bus and grouped source in bits 1 to 5. Address 1 holds the flags for external, timer 0, timer 1 and serial bus in bits 0 to 3. Address 2 holds the group enables for timer 2, real-time clock and time base in bits 0 to 2, and the matching group flags in bits 4 to 6. Unused bits and address 3 read as zero.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00, and ack and wake are low.
- R2: A pulse on a bit of src_evt sets the matching flag at address 1. A pulse on grp_evt sets the matching group flag at address 2. Flags are set even while the master enable is clear, and they stay set.
- R3: An interrupt is accepted at a clock edge when the master enable is 1, at least one enabled request is pending and stack_full is low. During the next cycle, ack and push_pc are high and vector holds the address of the accepted source.
- R4: Priority runs external, timer 0, timer 1, serial bus, grouped, highest first, with vectors 0x04, 0x08, 0x0C, 0x10 and 0x14.
- R5: Acceptance clears the master enable (address 0 bit 0). No further acknowledge occurs until software writes that bit to 1 again.
- R6: While stack_full is high, nothing is accepted. Acceptance happens at the first edge after stack_full falls.
- R7: Acceptance clears the flag of the accepted direct source only. Group flags are never cleared by hardware.
- R8: The grouped source is pending only when its enable (address 0 bit 5) is set and some group flag is set whose group enable is also set.
- R9: wake is high whenever any direct flag with its enable set is pending, or the grouped source is pending, independent of the master enable.
- R10: An event pulse in the same cycle as a software write to that flag leaves the flag set.
- R11: ack is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| src_evt | input | 4 | Event pulses: external, timer 0, timer 1, serial bus |
| grp_evt | input | 3 | Group event pulses: timer 2, real-time clock, time base |
| stack_full | input | 1 | Return stack has no free entry |
| ack | output | 1 | Interrupt acknowledge, one cycle |
| push_pc | output | 1 | Request to push the program counter |
| vector | output | 8 | Vector address, valid while ack is high |
| wake | output | 1 | Leave-halt request |

## Verification
A wrong master-enable or flag state shows up at the ports within one or two cycles. It appears either as an acknowledge that the scoreboard did not expect, or as a missing acknowledge that leaves an expected vector in the queue. A corrupted priority choice shows as a mismatched vector on the very acknowledge it affects. Flag and enable errors that cause no acknowledge are caught by reading the registers back and by sampling wake right after each event.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic [3:0]       src_evt,
  input  logic [2:0]       grp_evt,
  input  logic             stack_full,
  output logic             ack,
  output logic             push_pc,
  output logic [VEC_W-1:0] vector,
  output logic             wake
);
  localparam int NSRC = 5;

  logic             emi;
  logic [4:0]       en;
  logic [3:0]       flg;
  logic [2:0]       gen, gflg;
  logic             ack_q;
  logic [VEC_W-1:0] vec_q;

  logic             grp_pend;
  logic [NSRC-1:0]  pend;
  logic             take;
  logic [2:0]       sel;
  logic [3:0]       clr;

  assign grp_pend = en[4] & |(gen & gflg);
  assign pend     = {grp_pend, en[3:0] & flg};
  assign take     = emi & |pend & ~stack_full;
  assign wake     = |pend;

  always_comb begin
    sel = 3'd0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) sel = 3'(i);
  end

  always_comb begin
    clr = '0;
    if (take && sel < 3'd4) clr[sel[1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emi   <= 1'b0;
      en    <= '0;
      flg   <= '0;
      gen   <= '0;
      gflg  <= '0;
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd0) en <= wr_data[5:1];
      if (take) emi <= 1'b0;
      else if (wr_en && wr_addr == 2'd0) emi <= wr_data[0];
      flg  <= (((wr_en && wr_addr == 2'd1) ? wr_data[3:0] : flg) & ~clr) | src_evt;
      if (wr_en && wr_addr == 2'd2) gen <= wr_data[2:0];
      gflg <= ((wr_en && wr_addr == 2'd2) ? wr_data[6:4] : gflg) | grp_evt;
      ack_q <= take;
      if (take) vec_q <= VEC_W'((32'(sel) + 32'd1) * 32'd4);
    end
  end

  assign ack     = ack_q;
  assign push_pc = ack_q;
  assign vector  = vec_q;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {2'b00, en, emi};
      2'd1:    rd_data = {4'b0000, flg};
      2'd2:    rd_data = {1'b0, gflg, 1'b0, gen};
      default: rd_data = 8'h00;
    endcase
  end

  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_emi_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !emi);
  assert_stack_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> !$past(stack_full));
  assert_wake_before_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(wake));
  assert_vector_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vector == 8'h04 || vector == 8'h08 || vector == 8'h0C ||
             vector == 8'h10 || vector == 8'h14));
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flg & $past(src_evt)) == $past(src_evt)));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] src_evt = 0;
  logic [2:0] grp_evt = 0;
  logic       stack_full = 0;
  logic       ack, push_pc, wake;
  logic [7:0] vector;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse(input logic [3:0] s, input logic [2:0] g);
    @(negedge clk); src_evt = s; grp_evt = g;
    @(negedge clk); src_evt = 0; grp_evt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every ack must match the head of the expected queue (R3, R4)
  always @(negedge clk) begin
    if (rst_n && ack) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected ack actual=%0h expected=none", vector);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (vector !== e || push_pc !== 1'b1) begin
          fails++;
          $display("FAIL R3 vector/push actual=%0h/%0b expected=%0h/1", vector, push_pc, e);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; #1;
    rd("R1", 2'd0, 8'h00); rd("R1", 2'd1, 8'h00); rd("R1", 2'd2, 8'h00);
    check("R1", {7'b0, ack}, 8'h00); check("R1", {7'b0, wake}, 8'h00);

    wr(2'd0, 8'h3E);
    pulse(4'b0001, 3'b000);
    rd("R2", 2'd1, 8'h01);
    check("R9", {7'b0, wake}, 8'h01);
    pulse(4'b1100, 3'b000);
    idle(2);
    rd("R2", 2'd1, 8'h0D);

    stack_full = 1;
    wr(2'd0, 8'h3F);
    idle(4);
    rd("R6", 2'd0, 8'h3F);
    exp_q.push_back(8'h04);
    stack_full = 0;
    idle(4);
    rd("R5", 2'd0, 8'h3E);
    rd("R7", 2'd1, 8'h0C);
    check("R6", 8'(exp_q.size()), 8'h00);

    exp_q.push_back(8'h0C);
    wr(2'd0, 8'h3F); idle(3);
    exp_q.push_back(8'h10);
    wr(2'd0, 8'h3F); idle(3);
    rd("R7", 2'd1, 8'h00);
    check("R9", {7'b0, wake}, 8'h00);

    wr(2'd2, 8'h02);
    pulse(4'b0000, 3'b001);
    rd("R8", 2'd2, 8'h12);
    check("R8", {7'b0, wake}, 8'h00);
    wr(2'd0, 8'h3F); idle(3);
    rd("R8", 2'd0, 8'h3F);
    exp_q.push_back(8'h14);
    pulse(4'b0000, 3'b010);
    idle(3);
    rd("R7", 2'd2, 8'h32);
    rd("R5", 2'd0, 8'h3E);
    wr(2'd2, 8'h02);
    check("R9", {7'b0, wake}, 8'h00);

    @(negedge clk); wr_en = 1; wr_addr = 2'd1; wr_data = 8'h00; src_evt = 4'b0010;
    @(negedge clk); wr_en = 0; src_evt = 0;
    rd("R10", 2'd1, 8'h02);
    pulse(4'b0001, 3'b000);
    rd("R4", 2'd1, 8'h03);
    exp_q.push_back(8'h04);
    wr(2'd0, 8'h3F); idle(3);
    exp_q.push_back(8'h08);
    wr(2'd0, 8'h3F); idle(3);
    rd("R7", 2'd1, 8'h00);
    check("R11", 8'(exp_q.size()), 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule